// File: doc/BRIEF.md
# Dedicated-Charger Detection Sequencer

This block runs a two-phase probe on the USB data lines. Its job is to tell a dedicated wall charger apart from a charging host port and from a standard host port. A start pulse opens the first phase. In that phase the block turns on a weak current source on DP and keeps the DM sink off. When the first phase ends, both data-line comparators must read high. If they do, the second phase turns on the DM current sink while the DP source stays on. At the end of the second phase both lines must read low. A standard host port fails the first check, because its pull-down holds DM low. A charging host port fails one of the two checks: either its DP sink pulls DP low, or its DM voltage source holds DM high in the second phase.

All timing comes from a millisecond tick supplied from outside, so the length of each phase is a count of ticks set by a parameter. The two comparator inputs are asynchronous. They pass through a synchroniser and are sampled only on the tick that ends a phase. The block reports completion with a one-cycle done pulse and keeps a pass or fail flag until the next accepted start. If bus power is lost or an abort is requested, the probe stops at once and every enable is cleared. The analog sources, the comparators, mode control and pin drivers belong to the surrounding logic.

Top module: `dcp_probe_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle, busValid is high and abortReq is low. On acceptance the held pass/fail flags clear, and from the next cycle dpSrcEn is 1 and dmSinkEn is 0. A start pulse at any other time has no effect on the enables, the flags or the phase timing.
- R2: Phase 1 ends on the PH1_MS-th msTick counted after the acceptance cycle. A tick in the acceptance cycle itself is not counted.
- R3: At the end of phase 1, if both synchronised comparators read 1, the block enters phase 2: dmSinkEn becomes 1 and dpSrcEn stays 1. Otherwise the sequence ends at once with a fail.
- R4: Phase 2 ends on the PH2_MS-th msTick after it starts. The sequence passes only if both comparators read 0 at that point. Any line reading 1, including DM high from a charging host port, gives a fail.
- R5: Each comparator input passes through SYNC_STAGES flops. Only its value on the tick that ends a phase counts, so toggling earlier in the phase has no effect.
- R6: donePulse is high for exactly one cycle, on the cycle after the clock edge that samples the phase-ending tick. passFlag and failFlag are never both 1. The flag that was set stays until the next accepted start, and both enables are 0 from the cycle of donePulse on.
- R7: If busValid is low or abortReq is high during either phase, both enables read 0 from the next cycle. In that same cycle donePulse is 1 and failFlag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msTick | input | 1 | One-cycle pulse each millisecond |
| startPulse | input | 1 | Request to begin a detection |
| busValid | input | 1 | Bus supply is present and stable |
| abortReq | input | 1 | Request to stop a running detection |
| dpCmpRaw | input | 1 | Asynchronous DP comparator output (1 = above reference) |
| dmCmpRaw | input | 1 | Asynchronous DM comparator output (1 = above reference) |
| dpSrcEn | output | 1 | Enables the weak current source on DP |
| dmSinkEn | output | 1 | Enables the current sink on DM |
| donePulse | output | 1 | One-cycle pulse when a detection ends |
| passFlag | output | 1 | Held: the last detection found a dedicated charger |
| failFlag | output | 1 | Held: the last detection failed or was aborted |

## Verification
The enables change one cycle after the edge that accepts a start, ends a phase or sees an abort. donePulse and the flags appear one cycle after the edge that samples the final tick. The bench drives inputs on falling edges, so each check runs at the falling edge right after the clock edge that should have caused the change. Just before each phase-ending tick it also confirms that donePulse is still low.

The comparator values that count are set three cycles before the final tick, which is more than the synchroniser depth. Earlier in each phase the comparators toggle at random. Since only the values on the phase-ending ticks count, the expected outcome depends only on those values.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRC  = 2'd1,
    ST_SINK = 2'd2
  } seqState_t;

  typedef struct packed {
    logic clrCnt;
    logic selSink;
    logic clrResult;
    logic setPass;
    logic setFail;
  } seqStrobe_t;

endpackage

// File: rtl/dcp_sync.sv
module dcp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/dcp_datapath.sv
module dcp_datapath
  import dcp_pkg::*;
#(
  parameter int PH1_MS      = 100,
  parameter int PH2_MS      = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       dpCmpRaw,
  input  logic       dmCmpRaw,
  input  seqStrobe_t strobe,
  output logic       phaseEnd,
  output logic       dpHigh,
  output logic       dmHigh,
  output logic       donePulse,
  output logic       passFlag,
  output logic       failFlag
);

  localparam int MAX_MS = (PH1_MS > PH2_MS) ? PH1_MS : PH2_MS;
  localparam int CNT_W  = (MAX_MS < 2) ? 1 : $clog2(MAX_MS);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(PH1_MS - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(PH2_MS - 1);

  logic [CNT_W-1:0] msCnt;
  logic [CNT_W-1:0] lastCnt;
  logic [1:0]       cmpSync;

  dcp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({dpCmpRaw, dmCmpRaw}),
    .syncOut(cmpSync)
  );

  assign dpHigh   = cmpSync[1];
  assign dmHigh   = cmpSync[0];
  assign lastCnt  = strobe.selSink ? LAST2 : LAST1;
  assign phaseEnd = msTick && (msCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             msCnt <= '0;
    else if (strobe.clrCnt) msCnt <= '0;
    else if (msTick)       msCnt <= msCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      donePulse <= 1'b0;
      passFlag  <= 1'b0;
      failFlag  <= 1'b0;
    end else begin
      donePulse <= strobe.setPass | strobe.setFail;
      if (strobe.clrResult) begin
        passFlag <= 1'b0;
        failFlag <= 1'b0;
      end else if (strobe.setPass) begin
        passFlag <= 1'b1;
      end else if (strobe.setFail) begin
        failFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dcp_ctrl.sv
module dcp_ctrl
  import dcp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       busValid,
  input  logic       abortReq,
  input  logic       phaseEnd,
  input  logic       dpHigh,
  input  logic       dmHigh,
  output seqStrobe_t strobe,
  output logic       dpSrcEn,
  output logic       dmSinkEn
);

  seqState_t state, stateNext;
  logic      stopNow;

  assign stopNow = !busValid || abortReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.selSink = (state == ST_SINK);
    unique case (state)
      ST_IDLE: begin
        strobe.clrCnt = 1'b1;
        if (startPulse && !stopNow) begin
          strobe.clrResult = 1'b1;
          stateNext        = ST_SRC;
        end
      end
      ST_SRC: begin
        if (stopNow) begin
          strobe.setFail = 1'b1;
          strobe.clrCnt  = 1'b1;
          stateNext      = ST_IDLE;
        end else if (phaseEnd) begin
          strobe.clrCnt = 1'b1;
          if (dpHigh && dmHigh) begin
            stateNext = ST_SINK;
          end else begin
            strobe.setFail = 1'b1;
            stateNext      = ST_IDLE;
          end
        end
      end
      ST_SINK: begin
        if (stopNow) begin
          strobe.setFail = 1'b1;
          strobe.clrCnt  = 1'b1;
          stateNext      = ST_IDLE;
        end else if (phaseEnd) begin
          strobe.clrCnt = 1'b1;
          stateNext     = ST_IDLE;
          if (!dpHigh && !dmHigh) strobe.setPass = 1'b1;
          else                    strobe.setFail = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign dpSrcEn  = (state == ST_SRC) || (state == ST_SINK);
  assign dmSinkEn = (state == ST_SINK);

endmodule

// File: rtl/dcp_probe_seq.sv
module dcp_probe_seq
  import dcp_pkg::*;
#(
  parameter int PH1_MS      = 100,
  parameter int PH2_MS      = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic startPulse,
  input  logic busValid,
  input  logic abortReq,
  input  logic dpCmpRaw,
  input  logic dmCmpRaw,
  output logic dpSrcEn,
  output logic dmSinkEn,
  output logic donePulse,
  output logic passFlag,
  output logic failFlag
);

  seqStrobe_t strobe;
  logic       phaseEnd;
  logic       dpHigh;
  logic       dmHigh;

  dcp_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .busValid  (busValid),
    .abortReq  (abortReq),
    .phaseEnd  (phaseEnd),
    .dpHigh    (dpHigh),
    .dmHigh    (dmHigh),
    .strobe    (strobe),
    .dpSrcEn   (dpSrcEn),
    .dmSinkEn  (dmSinkEn)
  );

  dcp_datapath #(
    .PH1_MS     (PH1_MS),
    .PH2_MS     (PH2_MS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .msTick   (msTick),
    .dpCmpRaw (dpCmpRaw),
    .dmCmpRaw (dmCmpRaw),
    .strobe   (strobe),
    .phaseEnd (phaseEnd),
    .dpHigh   (dpHigh),
    .dmHigh   (dmHigh),
    .donePulse(donePulse),
    .passFlag (passFlag),
    .failFlag (failFlag)
  );

endmodule

// File: rtl/dcp_probe_seq_chk.sv
module dcp_probe_seq_chk (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic busValid,
  input logic dpSrcEn,
  input logic dmSinkEn,
  input logic donePulse,
  input logic passFlag,
  input logic failFlag
);

  a_r3_sink_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    dmSinkEn |-> dpSrcEn);

  a_r4_pass_after_sink: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passFlag) |-> $past(dmSinkEn));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(passFlag && failFlag));

  a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!dpSrcEn && !dmSinkEn));

  a_r6_result_held: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(passFlag) || !$stable(failFlag)) |-> (donePulse || $past(startPulse)));

  a_r7_bus_loss_clears: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> (!dpSrcEn && !dmSinkEn));

endmodule

bind dcp_probe_seq dcp_probe_seq_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .busValid  (busValid),
  .dpSrcEn   (dpSrcEn),
  .dmSinkEn  (dmSinkEn),
  .donePulse (donePulse),
  .passFlag  (passFlag),
  .failFlag  (failFlag)
);

// File: tb/tb_dcp_probe_seq.sv
module tb_dcp_probe_seq;

  localparam int PH1 = 100;
  localparam int PH2 = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic startPulse = 1'b0;
  logic busValid = 1'b1;
  logic abortReq = 1'b0;
  logic dpCmpRaw = 1'b0;
  logic dmCmpRaw = 1'b0;
  logic dpSrcEn, dmSinkEn, donePulse, passFlag, failFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dcp_probe_seq #(.PH1_MS(PH1), .PH2_MS(PH2), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .startPulse(startPulse),
    .busValid(busValid), .abortReq(abortReq), .dpCmpRaw(dpCmpRaw),
    .dmCmpRaw(dmCmpRaw), .dpSrcEn(dpSrcEn), .dmSinkEn(dmSinkEn),
    .donePulse(donePulse), .passFlag(passFlag), .failFlag(failFlag)
  );

  function automatic bit expPass(bit dp1, bit dm1, bit dp2, bit dm2);
    return dp1 && dm1 && !dp2 && !dm2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // inputs change at a falling edge; return at the next falling edge
  task automatic step(bit t);
    msTick = t;
    @(negedge clk);
    msTick = 1'b0;
  endtask

  task automatic runPhase(int n, bit fdp, bit fdm);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) begin
        dpCmpRaw = fdp;
        dmCmpRaw = fdm;
      end else begin
        dpCmpRaw = 1'($urandom);
        dmCmpRaw = 1'($urandom);
      end
      step(0); step(0); step(0);
      if (i == n - 1) chk("R2 no early done", int'(donePulse), 0);
      step(1);
    end
  endtask

  task automatic startSeq(bit withTick);
    startPulse = 1'b1;
    step(withTick);
    startPulse = 1'b0;
    chk("R1 src on", int'(dpSrcEn), 1);
    chk("R1 sink off", int'(dmSinkEn), 0);
    chk("R1 flags cleared", int'(passFlag | failFlag), 0);
  endtask

  task automatic runDetect(bit dp1, bit dm1, bit dp2, bit dm2, bit withTick);
    bit p;
    p = expPass(dp1, dm1, dp2, dm2);
    startSeq(withTick);
    runPhase(PH1, dp1, dm1);
    if (dp1 && dm1) begin
      chk("R3 sink on", int'(dmSinkEn), 1);
      chk("R3 src kept", int'(dpSrcEn), 1);
      chk("R3 no done", int'(donePulse), 0);
      runPhase(PH2, dp2, dm2);
      chk("R4 done", int'(donePulse), 1);
      chk("R4 R5 pass", int'(passFlag), int'(p));
      chk("R4 R5 fail", int'(failFlag), int'(!p));
    end else begin
      chk("R3 done", int'(donePulse), 1);
      chk("R3 fail", int'(failFlag), 1);
      chk("R3 pass", int'(passFlag), 0);
    end
    chk("R6 enables off", int'(dpSrcEn | dmSinkEn), 0);
    step(0);
    chk("R6 done one cycle", int'(donePulse), 0);
    chk("R6 pass held", int'(passFlag), int'(p));
    chk("R6 fail held", int'(failFlag), int'(!p));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    @(negedge clk); @(negedge clk);
    chk("R6 reset done", int'(donePulse), 0);
    chk("R6 reset flags", int'(passFlag | failFlag), 0);
    chk("R1 reset enables", int'(dpSrcEn | dmSinkEn), 0);
    rstN = 1'b1;
    step(0);

    // directed: dedicated charger, tick in acceptance cycle not counted
    runDetect(1, 1, 0, 0, 1);
    // charging host port: DM held high in phase 2
    runDetect(1, 1, 0, 1, 0);
    // standard host port: DM low in phase 1
    runDetect(1, 0, 0, 0, 0);
    // DP low in phase 1
    runDetect(0, 1, 0, 0, 0);

    // start while bus invalid is ignored; earlier fail result kept
    busValid = 1'b0;
    startPulse = 1'b1; step(0); startPulse = 1'b0;
    step(0);
    chk("R1 ignored src", int'(dpSrcEn), 0);
    chk("R1 ignored flags", int'(failFlag), 1);
    busValid = 1'b1;
    step(0);

    // start during phase 1 must not restart timing
    startSeq(0);
    runPhase(PH1 / 2, 1, 1);
    startPulse = 1'b1; step(0); startPulse = 1'b0;
    runPhase(PH1 - PH1 / 2, 0, 0);
    chk("R1 busy start ignored", int'(donePulse), 1);
    step(0);

    // bus loss during phase 1
    startSeq(0);
    runPhase(10, 1, 1);
    busValid = 1'b0; step(0);
    chk("R7 bus loss enables", int'(dpSrcEn | dmSinkEn), 0);
    chk("R7 bus loss done", int'(donePulse), 1);
    chk("R7 bus loss fail", int'(failFlag), 1);
    busValid = 1'b1; step(0);

    // abort request during phase 2
    startSeq(0);
    runPhase(PH1, 1, 1);
    runPhase(5, 0, 0);
    abortReq = 1'b1; step(0); abortReq = 1'b0;
    chk("R7 abort enables", int'(dpSrcEn | dmSinkEn), 0);
    chk("R7 abort done", int'(donePulse), 1);
    chk("R7 abort fail", int'(failFlag), 1);
    chk("R7 abort pass", int'(passFlag), 0);
    step(0);

    // random endpoints, biased toward reaching phase 2
    for (int k = 0; k < 14; k++) begin
      bit a, b, c, d;
      a = ($urandom % 4) != 0;
      b = ($urandom % 4) != 0;
      c = 1'($urandom);
      d = 1'($urandom);
      runDetect(a, b, c, d, 1'($urandom));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule